// File: doc/BRIEF.md
# BCD Calendar Counter Core

This block keeps time of day and a calendar date in packed BCD words. A low-speed reference clock of nominally 32.768 kHz runs it. Two down-counting dividers in series turn that clock into a one-second event. The first divider produces a sub-rate step. The second divider counts those steps and fires once per second. Each second event advances seconds, minutes and hours in 24-hour form. At midnight it also advances the day, month and two-digit year. Month lengths and leap years are handled for the years 2000 to 2099.

A freeze input stops all counting. While freeze is high, software may load new time and date words and new divider reload values through simple write strobes. The core has two states. COUNT is the running state and HOLD is the frozen state. It moves from COUNT to HOLD as soon as freeze is seen. It moves from HOLD back to COUNT on the first cycle that freeze is low. The HOLD state keeps both dividers at their reload values, so the first second after a release is a whole second. Reset enters HOLD.

Top module: `cal_top`

## Requirements
- R1: After reset the time word reads 0x000000 (00:00:00) and the date word reads 0x000101 (day 01, month 01, year 00). The dividers hold their defaults of 127 and 255, so the first second event comes 32769 cycles after reset is released.
- R2: While counting, sec_tick_o is a one-cycle pulse every (A+1)*(S+1) cycles, where A and S are the two reload values. The time word advances on the same clock edge that raises the pulse.
- R3: The first second event after freeze is released comes (A+1)*(S+1)+1 cycles after the release edge. This covers the one HOLD-to-COUNT cycle plus a full period.
- R4: Time word layout: hour tens [21:20], hour units [19:16], minute tens [14:12], minute units [11:8], second tens [6:4], second units [3:0]. Seconds carry 59→00 into minutes and minutes carry 59→00 into hours. Hours go 23→00 and advance the date. The date changes only together with a time rollover to 00:00:00, or by a load.
- R5: Date word layout: year tens [23:20], year units [19:16], month tens [12], month units [11:8], day tens [5:4], day units [3:0]. The day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. The month then advances.
- R6: February ends at day 29 when the year is divisible by 4 (year 00 included). In other years it ends at day 28.
- R7: At 23:59:59 on day 31 of month 12, the next second gives 00:00:00 on day 01 of month 01. The year advances, and 99 wraps to 00.
- R8: While freeze_i is high, no second event occurs and the time and date hold. On release, counting continues from the held or loaded values.
- R9: A time_wr_i or date_wr_i strobe loads its word only while freeze_i is high. When freeze_i is low the strobe has no effect.
- R10: Time bits [23:22], [15] and [7] and date bits [15:13], [7:6] always read zero, whatever value is written to them.
- R11: div_wr_i replaces the two reload values only while freeze_i is high. When freeze_i is low the strobe leaves the second period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_i | input | 1 | Freeze counting and allow loads |
| time_wr_i | input | 1 | Time word write strobe |
| time_wdata_i | input | 24 | Time word to load |
| date_wr_i | input | 1 | Date word write strobe |
| date_wdata_i | input | 24 | Date word to load |
| div_wr_i | input | 1 | Divider reload write strobe |
| adiv_i | input | AW | First-stage reload value A |
| sdiv_i | input | SW | Second-stage reload value S |
| time_o | output | 24 | Packed BCD time word |
| date_o | output | 24 | Packed BCD date word |
| sec_tick_o | output | 1 | One-cycle pulse per second |

## Verification
A load with freeze and a second event can fall in the same cycle. To provoke this, the bench waits for one tick and then counts down to the cycle just before the next one. In that cycle it raises freeze together with a load strobe. The bench then expects exactly the loaded word, with no increment applied and no pulse on sec_tick_o. A time rollover and a date rollover landing together is also driven many times, with random dates set just before midnight, and judged against an integer-arithmetic model in the bench.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam logic [23:0] TIME_MASK = 24'h3F7F7F;
    localparam logic [23:0] DATE_MASK = 24'hFF1F3F;
    localparam logic [23:0] DATE_RST  = 24'h000101;

    typedef enum logic {HOLD = 1'b0, COUNT = 1'b1} cal_state_t;

    // next BCD value of two digits, no range wrap
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // year divisible by 4: 10t+u == 2t+u (mod 4)
    function automatic logic is_leap(input logic [7:0] yr);
        logic [5:0] s;
        s = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        unique case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int AW = 7,
    parameter int SW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [AW-1:0] a_rl,
    input  logic [SW-1:0] s_rl,
    output logic          tick
);
    logic [AW-1:0] a_cnt;
    logic [SW-1:0] s_cnt;
    logic          a_end;

    assign a_end = (a_cnt == '0);
    assign tick  = run && a_end && (s_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_cnt <= '0;
            s_cnt <= '0;
        end else if (!run) begin
            a_cnt <= a_rl;
            s_cnt <= s_rl;
        end else if (a_end) begin
            a_cnt <= a_rl;
            s_cnt <= (s_cnt == '0) ? s_rl : s_cnt - 1'b1;
        end else begin
            a_cnt <= a_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cal_time_adv.sv
module cal_time_adv (
    input  logic [6:0] sec_i,
    input  logic [6:0] min_i,
    input  logic [5:0] hr_i,
    output logic [6:0] sec_o,
    output logic [6:0] min_o,
    output logic [5:0] hr_o,
    output logic       day_carry
);
    import cal_pkg::*;
    logic [7:0] s_n, m_n, h_n;
    logic       s_wrap, m_wrap, h_wrap;

    assign s_wrap = (sec_i == 7'h59);
    assign m_wrap = (min_i == 7'h59);
    assign h_wrap = (hr_i  == 6'h23);

    always_comb begin
        s_n = s_wrap ? 8'h00 : bcd_step({1'b0, sec_i});
        m_n = {1'b0, min_i};
        h_n = {2'b00, hr_i};
        day_carry = 1'b0;
        if (s_wrap) begin
            m_n = m_wrap ? 8'h00 : bcd_step({1'b0, min_i});
            if (m_wrap) begin
                h_n = h_wrap ? 8'h00 : bcd_step({2'b00, hr_i});
                day_carry = h_wrap;
            end
        end
    end

    assign sec_o = s_n[6:0];
    assign min_o = m_n[6:0];
    assign hr_o  = h_n[5:0];
endmodule

// File: rtl/cal_date_adv.sv
module cal_date_adv (
    input  logic [5:0] day_i,
    input  logic [4:0] mon_i,
    input  logic [7:0] yr_i,
    output logic [5:0] day_o,
    output logic [4:0] mon_o,
    output logic [7:0] yr_o
);
    import cal_pkg::*;
    logic [7:0] d_n, m_n, y_n;
    logic [7:0] last;

    assign last = month_last({3'b000, mon_i}, is_leap(yr_i));

    always_comb begin
        d_n = bcd_step({2'b00, day_i});
        m_n = {3'b000, mon_i};
        y_n = yr_i;
        if ({2'b00, day_i} == last) begin
            d_n = 8'h01;
            if (mon_i == 5'h12) begin
                m_n = 8'h01;
                y_n = (yr_i == 8'h99) ? 8'h00 : bcd_step(yr_i);
            end else begin
                m_n = bcd_step({3'b000, mon_i});
            end
        end
    end

    assign day_o = d_n[5:0];
    assign mon_o = m_n[4:0];
    assign yr_o  = y_n;
endmodule

// File: rtl/cal_top.sv
module cal_top #(
    parameter int AW    = 7,
    parameter int SW    = 15,
    parameter int A_DEF = 127,
    parameter int S_DEF = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze_i,
    input  logic          time_wr_i,
    input  logic [23:0]   time_wdata_i,
    input  logic          date_wr_i,
    input  logic [23:0]   date_wdata_i,
    input  logic          div_wr_i,
    input  logic [AW-1:0] adiv_i,
    input  logic [SW-1:0] sdiv_i,
    output logic [23:0]   time_o,
    output logic [23:0]   date_o,
    output logic          sec_tick_o
);
    import cal_pkg::*;

    cal_state_t    state_q, state_d;
    logic [AW-1:0] a_rl;
    logic [SW-1:0] s_rl;
    logic [23:0]   time_q, date_q;
    logic          tick_q, tick, run;
    logic [6:0]    sec_n, min_n;
    logic [5:0]    hr_n, day_n;
    logic [4:0]    mon_n;
    logic [7:0]    yr_n;
    logic          day_carry;

    // state transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            COUNT: if (freeze_i)  state_d = HOLD;
            HOLD:  if (!freeze_i) state_d = COUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD;
        else        state_q <= state_d;
    end

    assign run = (state_q == COUNT) && !freeze_i;

    // divider reload registers, writable only while frozen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rl <= AW'(A_DEF);
            s_rl <= SW'(S_DEF);
        end else if (freeze_i && div_wr_i) begin
            a_rl <= adiv_i;
            s_rl <= sdiv_i;
        end
    end

    cal_prescaler #(.AW(AW), .SW(SW)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .a_rl (a_rl),
        .s_rl (s_rl),
        .tick (tick)
    );

    cal_time_adv u_tadv (
        .sec_i    (time_q[6:0]),
        .min_i    (time_q[14:8]),
        .hr_i     (time_q[21:16]),
        .sec_o    (sec_n),
        .min_o    (min_n),
        .hr_o     (hr_n),
        .day_carry(day_carry)
    );

    cal_date_adv u_dadv (
        .day_i(date_q[5:0]),
        .mon_i(date_q[12:8]),
        .yr_i (date_q[23:16]),
        .day_o(day_n),
        .mon_o(mon_n),
        .yr_o (yr_n)
    );

    // output process: time, date and tick registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
            date_q <= DATE_RST;
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick;
            unique case (state_q)
                COUNT, HOLD: begin
                    if (freeze_i) begin
                        if (time_wr_i) time_q <= time_wdata_i & TIME_MASK;
                        if (date_wr_i) date_q <= date_wdata_i & DATE_MASK;
                    end else if (tick) begin
                        time_q <= {2'b00, hr_n, 1'b0, min_n, 1'b0, sec_n};
                        if (day_carry)
                            date_q <= {yr_n, 3'b000, mon_n, 2'b00, day_n};
                    end
                end
            endcase
        end
    end

    assign time_o     = time_q;
    assign date_o     = date_q;
    assign sec_tick_o = tick_q;
endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
    parameter int AW = 7,
    parameter int SW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          freeze_i,
    input logic          time_wr_i,
    input logic          date_wr_i,
    input logic [23:0]   time_o,
    input logic [23:0]   date_o,
    input logic          sec_tick_o,
    input logic [AW-1:0] a_rl,
    input logic [SW-1:0] s_rl
);
    AST_TICK_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> !sec_tick_o); // R8

    AST_TIME_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(time_o) |-> (sec_tick_o || $past(freeze_i && time_wr_i))); // R9

    AST_DATE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(date_o) |-> ((sec_tick_o && time_o == 24'h0) || $past(freeze_i && date_wr_i))); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((time_o & ~24'h3F7F7F) == 24'h0) && ((date_o & ~24'hFF1F3F) == 24'h0)); // R10

    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze_i |=> ($stable(a_rl) && $stable(s_rl))); // R11

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick_o && (a_rl != '0 || s_rl != '0)) |=> !sec_tick_o); // R2
endmodule

bind cal_top cal_checker #(.AW(AW), .SW(SW)) u_cal_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze_i  (freeze_i),
    .time_wr_i (time_wr_i),
    .date_wr_i (date_wr_i),
    .time_o    (time_o),
    .date_o    (date_o),
    .sec_tick_o(sec_tick_o),
    .a_rl      (a_rl),
    .s_rl      (s_rl)
);

// File: tb/test_cal_top.sv
module test_cal_top;
    localparam int AW = 7;
    localparam int SW = 15;

    logic clk = 1'b0, rst_n = 1'b0;
    logic freeze_i = 1'b0, time_wr_i = 1'b0, date_wr_i = 1'b0, div_wr_i = 1'b0;
    logic [23:0] time_wdata_i = '0, date_wdata_i = '0;
    logic [AW-1:0] adiv_i = '0;
    logic [SW-1:0] sdiv_i = '0;
    logic [23:0] time_o, date_o;
    logic sec_tick_o;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cal_top i_cal_top (.*);

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction
    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction
    function automatic logic [23:0] mk_t(input int h, input int m, input int s);
        return {2'b00, i2b(h)[5:0], 1'b0, i2b(m)[6:0], 1'b0, i2b(s)[6:0]};
    endfunction
    function automatic logic [23:0] mk_d(input int y, input int m, input int d);
        return {i2b(y), 3'b000, i2b(m)[4:0], 2'b00, i2b(d)[5:0]};
    endfunction
    // reference model: one second later
    task automatic model_next(inout logic [23:0] t, inout logic [23:0] d);
        int s, mi, h, dd, mo, y;
        s = b2i({1'b0, t[6:0]}); mi = b2i({1'b0, t[14:8]}); h = b2i({2'b0, t[21:16]});
        dd = b2i({2'b0, d[5:0]}); mo = b2i({3'b0, d[12:8]}); y = b2i(d[23:16]);
        s++;
        if (s == 60) begin s = 0; mi++; end
        if (mi == 60) begin mi = 0; h++; end
        if (h == 24) begin
            h = 0; dd++;
            if (dd > mdays(mo, y)) begin dd = 1; mo++; end
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
        end
        t = mk_t(h, mi, s);
        d = mk_d(y, mo, dd);
    endtask

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (sec_tick_o !== 1'b1);
    endtask

    task automatic set_div(input int a, input int s);
        @(negedge clk);
        freeze_i = 1; div_wr_i = 1; adiv_i = AW'(a); sdiv_i = SW'(s);
        @(negedge clk);
        div_wr_i = 0; freeze_i = 0;
    endtask

    // load while frozen, check held value, release
    task automatic load(input logic [23:0] t, input logic [23:0] d);
        @(negedge clk);
        freeze_i = 1; time_wr_i = 1; date_wr_i = 1; time_wdata_i = t; date_wdata_i = d;
        @(negedge clk);
        time_wr_i = 0; date_wr_i = 0;
        repeat (3) @(negedge clk);
        check("R8 held load time", time_o, t & 24'h3F7F7F);
        check("R8 held load date", date_o, d & 24'hFF1F3F);
        freeze_i = 0;
    endtask

    task automatic run_and_check(input logic [23:0] t0, input logic [23:0] d0, input int n, input string req);
        logic [23:0] et, ed;
        et = t0; ed = d0;
        load(t0, d0);
        for (int i = 0; i < n; i++) begin
            wait_tick();
            model_next(et, ed);
            check({req, " time"}, time_o, et);
            check({req, " date"}, date_o, ed);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [23:0] t0, snap;
        void'($urandom(32'd7117));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state and default divider
        check("R1 reset time", time_o, 24'h000000);
        check("R1 reset date", date_o, 24'h000101);
        check("R1 reset tick", {23'b0, sec_tick_o}, 24'h0);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (sec_tick_o !== 1'b1 && cnt < 40000);
        check("R1 default first tick cycles", 24'(cnt), 24'd32769);
        check("R1 time after one second", time_o, 24'h000001);

        set_div(1, 1); // N = 4 cycles per second

        // R3 first tick after release
        load(mk_t(12, 0, 0), mk_d(30, 6, 15));
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (sec_tick_o !== 1'b1 && cnt < 100);
        check("R3 first tick after release", 24'(cnt), 24'd5);
        // R2 period and pulse width
        @(negedge clk);
        check("R2 pulse one cycle", {23'b0, sec_tick_o}, 24'h0);
        cnt = 1;
        do begin @(negedge clk); cnt++; end while (sec_tick_o !== 1'b1 && cnt < 100);
        check("R2 tick period", 24'(cnt), 24'd4);
        check("R2 time advances", time_o, 24'h120002);

        // R8 freeze holds
        @(negedge clk); freeze_i = 1;
        snap = time_o;
        repeat (12) @(negedge clk);
        check("R8 frozen time", time_o, snap);
        check("R8 frozen no tick", {23'b0, sec_tick_o}, 24'h0);
        freeze_i = 0;

        // R9 load ignored while running
        wait_tick();
        snap = time_o;
        time_wr_i = 1; time_wdata_i = 24'h111111; date_wr_i = 1; date_wdata_i = 24'h990101;
        @(negedge clk);
        time_wr_i = 0; date_wr_i = 0;
        @(negedge clk);
        check("R9 ignored time write", time_o, snap);
        check("R9 ignored date write", date_o, mk_d(30, 6, 15));

        // R11 divider write ignored while running
        @(negedge clk);
        div_wr_i = 1; adiv_i = '0; sdiv_i = '0;
        @(negedge clk);
        div_wr_i = 0;
        wait_tick();
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (sec_tick_o !== 1'b1 && cnt < 100);
        check("R11 period unchanged", 24'(cnt), 24'd4);

        // R10 reserved bits
        load(24'hFFFFFF & 24'hC08080 | mk_t(5, 6, 7), 24'h00E0C0 | mk_d(11, 3, 4));
        check("R10 time reserved", time_o, mk_t(5, 6, 7));
        check("R10 date reserved", date_o, mk_d(11, 3, 4));

        // directed rollovers
        run_and_check(mk_t(0, 59, 58), mk_d(10, 5, 5), 3, "R4 minute hour carry");
        run_and_check(mk_t(23, 59, 59), mk_d(10, 4, 30), 1, "R5 30 day month");
        run_and_check(mk_t(23, 59, 59), mk_d(10, 1, 31), 1, "R5 31 day month");
        run_and_check(mk_t(23, 59, 59), mk_d(10, 11, 29), 2, "R5 day 29 to 30");
        run_and_check(mk_t(23, 59, 59), mk_d(23, 2, 28), 1, "R6 common february");
        run_and_check(mk_t(23, 59, 59), mk_d(24, 2, 28), 1, "R6 leap february 28");
        run_and_check(mk_t(23, 59, 59), mk_d(24, 2, 29), 1, "R6 leap february 29");
        run_and_check(mk_t(23, 59, 59), mk_d(0, 2, 28), 1, "R6 year 00 leap");
        run_and_check(mk_t(23, 59, 59), mk_d(99, 12, 31), 1, "R7 year wrap");
        run_and_check(mk_t(23, 59, 59), mk_d(45, 12, 31), 1, "R7 year advance");

        // R8/R9 freeze with load on the tick cycle
        wait_tick();
        repeat (3) @(negedge clk);
        freeze_i = 1; time_wr_i = 1; time_wdata_i = mk_t(8, 8, 8);
        @(negedge clk);
        time_wr_i = 0;
        check("R8 load beats tick", time_o, mk_t(8, 8, 8));
        check("R8 tick suppressed", {23'b0, sec_tick_o}, 24'h0);
        freeze_i = 0;

        // random
        for (int k = 0; k < 40; k++) begin
            int y, mo, dd, h, mi, s;
            y = $urandom % 100; mo = 1 + $urandom % 12; dd = 1 + $urandom % mdays(mo, y);
            if ($urandom % 2) begin h = 23; mi = 59; s = 55 + $urandom % 5; end
            else begin h = $urandom % 24; mi = $urandom % 60; s = $urandom % 60; end
            if ($urandom % 3 == 0) dd = mdays(mo, y);
            t0 = mk_t(h, mi, s);
            run_and_check(t0, mk_d(y, mo, dd), 1 + $urandom % 6, "R4 R5 R6 R7 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule